// File: doc/BRIEF.md
# Relocatable Memory Map Decoder

This block decodes every bus access in a 16-bit address space and steers it to one of five on-chip targets: internal RAM, a 64-byte block of control registers, a boot ROM, an EEPROM and an EPROM. When none of these claims the address, the access either goes to the external bus or is flagged as unmapped, depending on the operating mode. The memories themselves sit outside the block. It only produces the selects.

RAM and the register block can be moved. A mapping register holds a 4 KB page number for each of them. Its upper nibble gives the RAM page and its lower nibble gives the register page. After reset RAM sits at 0x0000 and the registers at 0x1000. The register can be rewritten only during a short window after reset, so the map is fixed before normal code runs.

Where regions overlap, a fixed priority picks the one that answers, from highest to lowest:

1. register block
2. RAM
3. boot ROM
4. EEPROM
5. EPROM
6. external bus

Two configuration inputs can remove the EEPROM and the EPROM from the map.

Top module: `mem_map_decoder`

## Requirements
- R1: After reset the mapping register holds 0x01, so RAM decodes at 0x0000 and the register block at 0x1000.
- R2: The register block answers the 64 addresses starting at its page base. It wins over RAM, so when both share a page the first 64 bytes of RAM are hidden.
- R3: RAM answers the first RAM_BYTES (default 512) addresses of its page. It wins over the boot ROM, EEPROM and EPROM.
- R4: A write with map_we high while the window is open loads map_wdata. Bits 7:4 give the RAM page and bits 3:0 give the register page. The new map decodes from the next clock cycle on.
- R5: The write window is open for the first 64 rising clock edges after reset. A write on the 64th edge is accepted, and any write from the 65th edge on is ignored.
- R6: The boot ROM answers 0xBF00 to 0xBFFF only in bootstrap mode (mode = 2'b10).
- R7: The EEPROM answers 0xB600 to 0xB7FF only while cfg_eeprom_on is 1. The EPROM answers 0xD000 to 0xFFFF only while cfg_eprom_on is 1.
- R8: An access that no on-chip region claims raises sel_ext in expanded mode (2'b01) and in test mode (2'b11). In single-chip mode (2'b00) and bootstrap mode (2'b10) it raises unmapped and no select.
- R9: While acc_valid is low, all select outputs and unmapped stay low.
- R10: While acc_valid is high, exactly one of the six selects and unmapped is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Bus access strobe |
| addr | input | 16 | Access address |
| map_we | input | 1 | Mapping register write enable |
| map_wdata | input | 8 | Mapping register data: RAM page in bits 7:4, register page in bits 3:0 |
| mode | input | 2 | Operating mode: 00 single-chip, 01 expanded, 10 bootstrap, 11 test |
| cfg_eprom_on | input | 1 | EPROM present in the map |
| cfg_eeprom_on | input | 1 | EEPROM present in the map |
| sel_reg | output | 1 | Register block select |
| sel_ram | output | 1 | RAM select |
| sel_boot | output | 1 | Boot ROM select |
| sel_eeprom | output | 1 | EEPROM select |
| sel_eprom | output | 1 | EPROM select |
| sel_ext | output | 1 | External bus access |
| unmapped | output | 1 | Access hit no region in a mode without an external bus |

## Verification
Several properties are checked by assertions on every cycle:

- the outputs are one-hot or idle, following the access strobe;
- the register block claims its own 64 bytes;
- the boot ROM never answers outside bootstrap mode;
- external access and unmapped follow the mode bit;
- a write inside the window loads the mapping register;
- the mapping register holds steady once the window has closed.

Other behaviour only shows in the bench's scenarios, which compare every cycle against a behavioural map model:

- the exact window boundary, with writes on the 64th and 65th edges;
- the reset map;
- the RAM-over-EPROM overlap;
- the effect of the configuration bits on the decode.

// File: rtl/mem_map_decoder.sv
module mem_map_decoder #(
  parameter int          ADDR_W     = 16,
  parameter int          RAM_BYTES  = 512,
  parameter int          REG_BYTES  = 64,
  parameter logic [7:0]  MAP_INIT   = 8'h01,
  parameter int          WIN        = 64,
  parameter int          BOOT_BASE  = 'hBF00,
  parameter int          BOOT_BYTES = 256,
  parameter int          EEP_BASE   = 'hB600,
  parameter int          EEP_BYTES  = 512,
  parameter int          EPR_BASE   = 'hD000,
  parameter int          EPR_BYTES  = 12288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              map_we,
  input  logic [7:0]        map_wdata,
  input  logic [1:0]        mode,
  input  logic              cfg_eprom_on,
  input  logic              cfg_eeprom_on,
  output logic              sel_reg,
  output logic              sel_ram,
  output logic              sel_boot,
  output logic              sel_eeprom,
  output logic              sel_eprom,
  output logic              sel_ext,
  output logic              unmapped
);

  localparam int             OFS_W    = ADDR_W - 4;
  localparam int             CNT_W    = $clog2(WIN + 1);
  localparam logic [1:0]     MODE_BOOT = 2'b10;
  localparam logic [OFS_W:0] RAM_LIM  = (OFS_W+1)'(RAM_BYTES);
  localparam logic [OFS_W:0] REG_LIM  = (OFS_W+1)'(REG_BYTES);
  localparam logic [ADDR_W:0] BOOT_LO = (ADDR_W+1)'(BOOT_BASE);
  localparam logic [ADDR_W:0] BOOT_HI = (ADDR_W+1)'(BOOT_BASE + BOOT_BYTES);
  localparam logic [ADDR_W:0] EEP_LO  = (ADDR_W+1)'(EEP_BASE);
  localparam logic [ADDR_W:0] EEP_HI  = (ADDR_W+1)'(EEP_BASE + EEP_BYTES);
  localparam logic [ADDR_W:0] EPR_LO  = (ADDR_W+1)'(EPR_BASE);
  localparam logic [ADDR_W:0] EPR_HI  = (ADDR_W+1)'(EPR_BASE + EPR_BYTES);
  localparam logic [CNT_W-1:0] WIN_C  = CNT_W'(WIN);

  logic [7:0]       map_q;
  logic [CNT_W-1:0] age_q;
  logic             win_open;

  assign win_open = (age_q < WIN_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= MAP_INIT;
      age_q <= '0;
    end else begin
      if (win_open) age_q <= age_q + 1'b1;
      if (win_open && map_we) map_q <= map_wdata;
    end
  end

  logic [3:0]       page;
  logic [OFS_W:0]   ofs;
  logic [ADDR_W:0]  a_ext;
  logic in_reg, in_ram, in_boot, in_eep, in_epr, any_int;

  assign page  = addr[ADDR_W-1 -: 4];
  assign ofs   = {1'b0, addr[OFS_W-1:0]};
  assign a_ext = {1'b0, addr};

  assign in_reg  = (page == map_q[3:0]) && (ofs < REG_LIM);
  assign in_ram  = (page == map_q[7:4]) && (ofs < RAM_LIM);
  assign in_boot = (mode == MODE_BOOT) && (a_ext >= BOOT_LO) && (a_ext < BOOT_HI);
  assign in_eep  = cfg_eeprom_on && (a_ext >= EEP_LO) && (a_ext < EEP_HI);
  assign in_epr  = cfg_eprom_on && (a_ext >= EPR_LO) && (a_ext < EPR_HI);
  assign any_int = in_reg || in_ram || in_boot || in_eep || in_epr;

  assign sel_reg    = acc_valid && in_reg;
  assign sel_ram    = acc_valid && in_ram && !in_reg;
  assign sel_boot   = acc_valid && in_boot && !in_reg && !in_ram;
  assign sel_eeprom = acc_valid && in_eep && !in_reg && !in_ram && !in_boot;
  assign sel_eprom  = acc_valid && in_epr && !in_reg && !in_ram && !in_boot && !in_eep;
  assign sel_ext    = acc_valid && !any_int && mode[0];
  assign unmapped   = acc_valid && !any_int && !mode[0];

  logic [6:0] outs;
  assign outs = {sel_reg, sel_ram, sel_boot, sel_eeprom, sel_eprom, sel_ext, unmapped};

  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $onehot(outs));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (outs == 7'd0));
  a_r2_reg_claims: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && page == map_q[3:0] && addr[OFS_W-1:6] == '0) |-> sel_reg);
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && map_we) |=> (map_q == $past(map_wdata)));
  a_r5_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(map_q));
  a_r6_boot_mode: assert property (@(posedge clk) disable iff (!rst_n)
    sel_boot |-> (mode == MODE_BOOT && addr[ADDR_W-1:8] == 8'hBF));
  a_r8_ext_mode: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ext |-> mode[0]);
  a_r8_unmapped_mode: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> !mode[0]);

endmodule

// File: tb/tb_mem_map_decoder.sv
`timescale 1ns/1ps
module tb_mem_map_decoder;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, map_we = 0, cfg_eprom_on = 1, cfg_eeprom_on = 1;
  logic [15:0] addr = 0;
  logic [7:0]  map_wdata = 0;
  logic [1:0]  mode = 2'b00;
  logic sel_reg, sel_ram, sel_boot, sel_eeprom, sel_eprom, sel_ext, unmapped;

  int total = 0, bad = 0;
  int cyc = 0;
  int ram_pg = 0, reg_pg = 1;
  string tag = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  mem_map_decoder dut (.*);

  // reference map model: window count and pages
  always @(posedge clk) if (rst_n) begin
    if (map_we && cyc < 64) begin
      ram_pg = int'(map_wdata[7:4]);
      reg_pg = int'(map_wdata[3:0]);
    end
    cyc = cyc + 1;
  end

  // expected {reg, ram, boot, eeprom, eprom, ext, unmapped}
  function automatic logic [6:0] expect_outs();
    int a = int'(addr);
    if (!acc_valid) return 7'd0;
    if (a >= reg_pg*4096 && a < reg_pg*4096 + 64) return 7'b1000000;
    if (a >= ram_pg*4096 && a < ram_pg*4096 + 512) return 7'b0100000;
    if (mode == 2'b10 && a >= 'hBF00 && a <= 'hBFFF) return 7'b0010000;
    if (cfg_eeprom_on && a >= 'hB600 && a <= 'hB7FF) return 7'b0001000;
    if (cfg_eprom_on && a >= 'hD000) return 7'b0000100;
    if (mode[0]) return 7'b0000010;
    return 7'b0000001;
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    logic [6:0] got, exp;
    got = {sel_reg, sel_ram, sel_boot, sel_eeprom, sel_eprom, sel_ext, unmapped};
    exp = expect_outs();
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%h got=%b exp=%b", tag, addr, got, exp);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic acc(input logic [15:0] a);
    acc_valid = 1; addr = a; step();
  endtask

  task automatic wr(input logic [7:0] d);
    acc_valid = 0; map_we = 1; map_wdata = d; step(); map_we = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R1: reset map
    tag = "R1"; acc(16'h0000); acc(16'h01FF); acc(16'h1000);
    tag = "R3"; acc(16'h0200);
    tag = "R2"; acc(16'h103F); acc(16'h1040);
    // R4 and R2: both bases at 0x3000, registers hide RAM start
    tag = "R4"; wr(8'h33);
    tag = "R2"; acc(16'h3000); acc(16'h303F); acc(16'h3040); acc(16'h0000);
    // R4 and R3: RAM over EPROM at 0xD000, registers at 0x2000
    tag = "R4"; wr(8'hD2);
    tag = "R3"; acc(16'hD000); acc(16'hD1FF);
    tag = "R7"; acc(16'hD200); acc(16'hFFFF); acc(16'hB600); acc(16'hB7FF); acc(16'hB800);
    cfg_eprom_on = 0; acc(16'hD200);
    cfg_eeprom_on = 0; acc(16'hB600);
    tag = "R8"; mode = 2'b01; acc(16'hD200); acc(16'h8000);
    mode = 2'b11; acc(16'hB700);
    cfg_eprom_on = 1; cfg_eeprom_on = 1;
    tag = "R6"; mode = 2'b10; acc(16'hBF00); acc(16'hBFC0); acc(16'hBFFF); acc(16'hBEFF);
    mode = 2'b00; acc(16'hBF00);
    mode = 2'b01; acc(16'hBF80);
    tag = "R8"; mode = 2'b10; acc(16'hC000);
    mode = 2'b00;
    tag = "R9"; acc_valid = 0; addr = 16'h2000; step(); addr = 16'hD000; step();
    tag = "R10"; acc(16'h2010); acc(16'h5555);
    // R5: window edge
    acc_valid = 0;
    while (cyc != 63) step();
    tag = "R5"; wr(8'h45);
    wr(8'h67);
    acc(16'h5000); acc(16'h4000); acc(16'h7000); acc(16'h6000);
    wr(8'h00);
    acc(16'h0000); acc(16'h5020);
    tag = "R10"; mode = 2'b01; acc(16'h9000); acc(16'h4100);
    acc_valid = 0; step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule